// File: doc/BRIEF.md
# Link Training Supervisor with Stuck-Speed-Change Recovery

This block supervises bring-up of a serial link controller. On a start pulse it first rewrites the link capability word so that the maximum speed field reads first generation. It then raises the training enable and polls the controller's two debug words at fixed intervals. A poll counts as link up only when the up flag is set and the training-in-progress flag is clear.

When a poll finds no link, the block reads the PHY receive-status register through a request/acknowledge register-access port. If the training state is the one in which a speed change can deadlock, and the receiver reports not valid, the block breaks the deadlock. It sets the receive-data and receive-PLL override bits of the PHY receive-override register by read-modify-write, holds them for a fixed time, and then clears them the same way. All delays are counted in microseconds from one prescaled tick, so the clock rate is a parameter.

The block ends each bring-up with a one-cycle done pulse, together with either a link-up pulse or a fail pulse. A fail follows when the poll budget runs out or when the PHY port reports an access error. The training state seen at the most recent poll stays readable on a status output.

Top module: `link_train_sup`

## Requirements
- R1: After reset, train_en, done, link_up, fail, cap_we and phy_req are 0 and last_state is 0.
- R2: On start in the idle state, cap_we is high for exactly one cycle with cap_wdata equal to cap_rd with bits [3:0] replaced by 4'h1, while train_en is still 0. train_en rises in the next cycle and stays high.
- R3: A poll sees the link up when dbg_hi bit 4 is 1 and dbg_hi bit 29 is 0. The block then pulses done and link_up together and makes no PHY access for that poll.
- R4: A poll that does not see the link up reads PHY address 16'h100D. last_state holds dbg_lo[5:0] sampled at the most recent poll.
- R5: When bit 0 of the data read from 16'h100D is 1, or last_state is not 6'h0D, the poll makes no access to 16'h1005.
- R6: When last_state is 6'h0D and bit 0 of the 16'h100D data is 0, the block reads 16'h1005 and writes back the value OR 16'h0028. After the hold it reads 16'h1005 again and writes back that value AND ~16'h0028.
- R7: From the acknowledge of the setting write to the next PHY request, the override hold lasts HOLD_US microseconds (HOLD_US*CLK_PER_US cycles) plus at most 4 cycles.
- R8: From the acknowledge of the last PHY access of a failed poll to the request of the next poll, the gap lasts GAP_US*CLK_PER_US cycles plus at most 4 cycles.
- R9: After MAX_CHECKS polls without link up, done and fail pulse together, and exactly MAX_CHECKS reads of 16'h100D have been made.
- R10: A PHY acknowledge with phy_err high ends the bring-up with done and fail in the next cycle, and no further PHY request follows.
- R11: While phy_req is high and phy_ack is low, phy_req, phy_we, phy_addr and phy_wdata stay unchanged.
- R12: A start pulse during a running bring-up has no effect: no second capability write occurs and the run completes as it would have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up (accepted only when idle) |
| dbg_lo | input | 32 | First debug word; bits [5:0] are the training state |
| dbg_hi | input | 32 | Second debug word; bit 4 link up, bit 29 training in progress |
| cap_rd | input | 32 | Current link capability word |
| cap_we | output | 1 | Capability write strobe |
| cap_wdata | output | 32 | Capability word with the speed field forced to first generation |
| train_en | output | 1 | Training state machine enable |
| phy_req | output | 1 | PHY register access request, held until acknowledged |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY access acknowledge (one cycle) |
| phy_err | input | 1 | Access error, valid with phy_ack |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |
| done | output | 1 | Bring-up finished (one-cycle pulse) |
| link_up | output | 1 | Bring-up succeeded (one-cycle pulse) |
| fail | output | 1 | Bring-up failed (one-cycle pulse) |
| last_state | output | 6 | Training state at the most recent poll |

## Verification
The assertions assume the PHY port acknowledges only a request that is pending, with a one-cycle phy_ack, and that phy_err and phy_rdata are meaningful only in that cycle. The bench's register model keeps to this. It answers each request once, after a random latency of zero to two cycles, and drops the acknowledge in the following cycle. The debug words are changed only between polls or at points the bench chooses, and never glitch within a cycle, so each poll samples a stable pair.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int DBG_W       = 32;
  localparam int PHY_AW      = 16;
  localparam int PHY_DW      = 16;
  localparam int ST_W        = 6;
  localparam int SPD_W       = 4;
  localparam int UP_BIT      = 4;
  localparam int TRAINING_BIT = 29;
  localparam int RXVALID_BIT = 0;

  localparam logic [ST_W-1:0]   STUCK_ST   = 6'h0D;
  localparam logic [PHY_AW-1:0] RXSTAT_ADR = 16'h100D;
  localparam logic [PHY_AW-1:0] RXOVRD_ADR = 16'h1005;
  // receive data enable (bit 5) and receive PLL enable (bit 3)
  localparam logic [PHY_DW-1:0] OVRD_MASK  = 16'h0028;
  localparam logic [SPD_W-1:0]  GEN1_SPD   = 4'h1;

  typedef enum logic [3:0] {
    S_IDLE, S_CAP, S_CHECK, S_RD_RX, S_RD_OV1, S_WR_OV1,
    S_HOLD, S_RD_OV2, S_WR_OV2, S_GAP
  } sup_state_e;

  function automatic logic link_ok(input logic [DBG_W-1:0] w);
    return w[UP_BIT] && !w[TRAINING_BIT];
  endfunction

  function automatic logic [ST_W-1:0] train_state(input logic [DBG_W-1:0] w);
    return w[ST_W-1:0];
  endfunction

  function automatic logic is_stuck(input logic [ST_W-1:0] st, input logic rx_valid);
    return (st == STUCK_ST) && !rx_valid;
  endfunction

  function automatic logic [PHY_DW-1:0] ovrd_on(input logic [PHY_DW-1:0] v);
    return v | OVRD_MASK;
  endfunction

  function automatic logic [PHY_DW-1:0] ovrd_off(input logic [PHY_DW-1:0] v);
    return v & ~OVRD_MASK;
  endfunction

  function automatic logic [DBG_W-1:0] force_gen1(input logic [DBG_W-1:0] cap);
    return {cap[DBG_W-1:SPD_W], GEN1_SPD};
  endfunction
endpackage

// File: rtl/lts_tick.sv
module lts_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre;

  assign tick = run && (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (clr)    pre <= '0;
    else if (run)    pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  // R7
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= LAST);
endmodule

// File: rtl/lts_delay.sv
module lts_delay #(
  parameter int CLK_PER_US = 100,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_us,
  output logic             expire
);
  logic [LEN_W-1:0] rem;
  logic             busy;
  logic             us_tick;

  lts_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .run  (busy),
    .tick (us_tick)
  );

  assign expire = busy && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      rem  <= len_us;
    end else if (expire) begin
      busy <= 1'b0;
    end else if (us_tick) begin
      rem  <= rem - 1'b1;
    end
  end

  // R7 R8: a running delay does not end before its count reaches zero
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && rem != '0) |=> busy);
endmodule

// File: rtl/link_train_sup.sv
module link_train_sup
  import lts_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int GAP_US     = 10,
  parameter int HOLD_US    = 3000,
  parameter int MAX_CHECKS = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DBG_W-1:0]  dbg_lo,
  input  logic [DBG_W-1:0]  dbg_hi,
  input  logic [DBG_W-1:0]  cap_rd,
  output logic              cap_we,
  output logic [DBG_W-1:0]  cap_wdata,
  output logic              train_en,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic              phy_err,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              done,
  output logic              link_up,
  output logic              fail,
  output logic [ST_W-1:0]   last_state
);
  localparam int MAX_US = (HOLD_US > GAP_US) ? HOLD_US : GAP_US;
  localparam int LEN_W  = $clog2(MAX_US + 1);
  localparam int CNT_W  = $clog2(MAX_CHECKS + 1);
  localparam logic [CNT_W-1:0] LAST_CHK = CNT_W'(MAX_CHECKS - 1);

  sup_state_e        state, state_nx;
  logic [CNT_W-1:0]  chk_cnt;
  logic [PHY_DW-1:0] shadow;
  logic [LEN_W-1:0]  dly_len;
  logic              dly_start, dly_expire;

  // named events
  logic ev_ack_ok, ev_fault, ev_up, ev_stuck, ev_timeout, ev_start;

  assign phy_req = (state == S_RD_RX) || (state == S_RD_OV1) || (state == S_WR_OV1) ||
                   (state == S_RD_OV2) || (state == S_WR_OV2);
  assign phy_we    = (state == S_WR_OV1) || (state == S_WR_OV2);
  assign phy_addr  = (state == S_RD_RX) ? RXSTAT_ADR : RXOVRD_ADR;
  assign phy_wdata = (state == S_WR_OV1) ? ovrd_on(shadow) : ovrd_off(shadow);

  assign cap_we    = (state == S_CAP);
  assign cap_wdata = force_gen1(cap_rd);

  assign ev_start   = (state == S_IDLE) && start;
  assign ev_ack_ok  = phy_req && phy_ack && !phy_err;
  assign ev_fault   = phy_req && phy_ack && phy_err;
  assign ev_up      = (state == S_CHECK) && link_ok(dbg_hi);
  assign ev_stuck   = (state == S_RD_RX) && ev_ack_ok &&
                      is_stuck(last_state, phy_rdata[RXVALID_BIT]);
  assign ev_timeout = (state == S_GAP) && dly_expire && (chk_cnt == LAST_CHK);

  assign dly_len   = (state == S_WR_OV1) ? LEN_W'(HOLD_US) : LEN_W'(GAP_US);
  assign dly_start = ev_ack_ok && (((state == S_RD_RX) && !ev_stuck) ||
                                   (state == S_WR_OV1) || (state == S_WR_OV2));

  lts_delay #(.CLK_PER_US(CLK_PER_US), .LEN_W(LEN_W)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dly_start),
    .len_us(dly_len),
    .expire(dly_expire)
  );

  always_comb begin
    state_nx = state;
    if (ev_fault) begin
      state_nx = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:   if (start) state_nx = S_CAP;
        S_CAP:    state_nx = S_CHECK;
        S_CHECK:  state_nx = ev_up ? S_IDLE : S_RD_RX;
        S_RD_RX:  if (ev_ack_ok) state_nx = ev_stuck ? S_RD_OV1 : S_GAP;
        S_RD_OV1: if (ev_ack_ok) state_nx = S_WR_OV1;
        S_WR_OV1: if (ev_ack_ok) state_nx = S_HOLD;
        S_HOLD:   if (dly_expire) state_nx = S_RD_OV2;
        S_RD_OV2: if (ev_ack_ok) state_nx = S_WR_OV2;
        S_WR_OV2: if (ev_ack_ok) state_nx = S_GAP;
        S_GAP:    if (dly_expire) state_nx = ev_timeout ? S_IDLE : S_CHECK;
        default:  state_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      chk_cnt    <= '0;
      shadow     <= '0;
      train_en   <= 1'b0;
      done       <= 1'b0;
      link_up    <= 1'b0;
      fail       <= 1'b0;
      last_state <= '0;
    end else begin
      state   <= state_nx;
      done    <= ev_up || ev_fault || ev_timeout;
      link_up <= ev_up;
      fail    <= ev_fault || ev_timeout;
      if (ev_start) begin
        train_en <= 1'b0;
        chk_cnt  <= '0;
      end
      if (state == S_CAP) train_en <= 1'b1;
      if (state == S_CHECK) last_state <= train_state(dbg_lo);
      if (ev_ack_ok && ((state == S_RD_OV1) || (state == S_RD_OV2))) shadow <= phy_rdata;
      if ((state == S_GAP) && dly_expire && !ev_timeout) chk_cnt <= chk_cnt + 1'b1;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

  // R2
  train_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> $past(cap_we));

  // R3
  up_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (done && !fail && $past(link_ok(dbg_hi))));

  // R10
  fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (fail && done && !phy_req));

  // R9
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (fail && done));

  // R2
  access_needs_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> train_en);
endmodule

// File: tb/sim_link_train_sup.sv
module sim_link_train_sup;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 2;
  localparam int GAP  = 3;
  localparam int HOLD = 5;
  localparam int MAXC = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] dbg_lo = '0, dbg_hi = '0, cap_rd = '0;
  logic cap_we, train_en, phy_req, phy_we, done, link_up, fail;
  logic [31:0] cap_wdata;
  logic [15:0] phy_addr, phy_wdata;
  logic phy_ack = 1'b0, phy_err = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic [5:0] last_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_sup #(.CLK_PER_US(CPU), .GAP_US(GAP), .HOLD_US(HOLD), .MAX_CHECKS(MAXC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
    .cap_rd(cap_rd), .cap_we(cap_we), .cap_wdata(cap_wdata), .train_en(train_en),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_err(phy_err), .phy_rdata(phy_rdata), .done(done),
    .link_up(link_up), .fail(fail), .last_state(last_state));

  int n_chk = 0, n_bad = 0;

  // PHY model state
  logic        rx_bit = 1'b0;
  logic        inj_err = 1'b0;
  logic [15:0] reg_ovrd = '0;
  int cyc = 0, t_ack = 0;
  bit inflight = 0, have_ack = 0, last_was_set = 0;
  int lat = 0;
  int n_rd_rx = 0, n_rd_ov = 0, n_wr_ov = 0, n_other = 0, n_req_after_err = 0;
  int n_hold = 0, n_gap = 0, v_hold = 0, v_gap = 0;
  bit err_seen = 0;
  // monitor state
  int n_done = 0, n_up = 0, n_fail = 0, n_cap = 0, n_cap_train = 0;
  logic [31:0] cap_seen = '0;

  function automatic bit exp_up(input logic [31:0] w);
    return w[4] & ~w[29];
  endfunction
  function automatic bit exp_stuck(input logic [31:0] lo, input logic rx);
    return (lo[5:0] == 6'd13) && (rx == 1'b0);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) n_done <= n_done + 1;
    if (link_up) n_up <= n_up + 1;
    if (fail) n_fail <= n_fail + 1;
    if (cap_we) begin
      n_cap <= n_cap + 1;
      cap_seen <= cap_wdata;
      if (train_en) n_cap_train <= n_cap_train + 1;
    end
    if (phy_ack) begin
      phy_ack <= 1'b0;
      phy_err <= 1'b0;
    end else if (phy_req) begin
      if (err_seen) n_req_after_err <= n_req_after_err + 1;
      if (!inflight) begin
        inflight <= 1;
        lat <= int'($urandom % 3);
        if (have_ack) begin
          if (phy_addr == 16'h100D && !phy_we) begin
            n_gap <= n_gap + 1;
            if (cyc - t_ack < GAP*CPU || cyc - t_ack > GAP*CPU + 4) v_gap <= v_gap + 1;
          end else if (last_was_set) begin
            n_hold <= n_hold + 1;
            if (cyc - t_ack < HOLD*CPU || cyc - t_ack > HOLD*CPU + 4) v_hold <= v_hold + 1;
          end
        end
      end else if (lat != 0) begin
        lat <= lat - 1;
      end else begin
        inflight <= 0;
        phy_ack <= 1'b1;
        have_ack <= 1;
        t_ack <= cyc;
        last_was_set <= 0;
        if (inj_err && phy_addr == 16'h1005) begin
          phy_err <= 1'b1;
          err_seen <= 1;
        end else if (phy_addr == 16'h100D && !phy_we) begin
          n_rd_rx <= n_rd_rx + 1;
          phy_rdata <= 16'h5A40 | {15'd0, rx_bit};
        end else if (phy_addr == 16'h1005 && !phy_we) begin
          n_rd_ov <= n_rd_ov + 1;
          phy_rdata <= reg_ovrd;
        end else if (phy_addr == 16'h1005) begin
          n_wr_ov <= n_wr_ov + 1;
          reg_ovrd <= phy_wdata;
          last_was_set <= (phy_wdata & 16'h0028) == 16'h0028;
        end else begin
          n_other <= n_other + 1;
        end
      end
    end
  end

  task automatic ck(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int b_done, b_up, b_fail, b_cap, b_rx, b_rdov, b_wrov;

  // rel_rd/rel_wr: make link come up after that many rx reads / ovrd writes (0 = never)
  task automatic run(input logic [31:0] cap, input int rel_rd, input int rel_wr, input bit poke);
    bit poked = 0;
    int k;
    b_done = n_done; b_up = n_up; b_fail = n_fail; b_cap = n_cap;
    b_rx = n_rd_rx; b_rdov = n_rd_ov; b_wrov = n_wr_ov;
    have_ack = 0;
    cap_rd = cap;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (k = 0; k < 20000 && n_done == b_done; k++) begin
      @(negedge clk);
      if (rel_rd > 0 && n_rd_rx - b_rx >= rel_rd) dbg_hi = 32'h0000_0010;
      if (rel_wr > 0 && n_wr_ov - b_wrov >= rel_wr) dbg_hi = 32'h0000_0010;
      if (poke && !poked && n_rd_rx - b_rx == 1) begin
        start = 1'b1; poked = 1;
        @(negedge clk) start = 1'b0;
      end
    end
    if (n_done == b_done) ck("WDOG", "run timed out", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL WDOG: actual hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    ck("R1", "train_en", train_en, 0); ck("R1", "phy_req", phy_req, 0);
    ck("R1", "done", done, 0); ck("R1", "link_up", link_up, 0);
    ck("R1", "fail", fail, 0); ck("R1", "cap_we", cap_we, 0);
    ck("R1", "last_state", last_state, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ck("R1", "idle after reset", {train_en, phy_req, done}, 0);

    // R2 R3: link up at first poll
    dbg_lo = 32'h0000_0011; dbg_hi = 32'h0000_0010;
    run(32'hABCD_1237, 0, 0, 0);
    ck("R2", "cap write count", n_cap - b_cap, 1);
    ck("R2", "cap_wdata gen1", cap_seen, 32'hABCD_1231);
    ck("R2", "train_en low during cap write", n_cap_train, 0);
    ck("R2", "train_en held", train_en, 1);
    ck("R3", "link_up pulse", n_up - b_up, 1);
    ck("R3", "no fail", n_fail - b_fail, 0);
    ck("R3", "no phy access", n_rd_rx - b_rx, 0);
    ck("R4", "last_state", last_state, 6'h11);

    // R6: stuck once, link comes up after the clearing write
    dbg_lo = 32'hFFFF_FF0D; dbg_hi = 32'h2000_0010; rx_bit = 1'b0; reg_ovrd = 16'h0F41;
    run(32'h0000_00F2, 0, 2, 0);
    ck("R6", "ovrd reads", n_rd_ov - b_rdov, 2);
    ck("R6", "ovrd writes", n_wr_ov - b_wrov, 2);
    ck("R6", "ovrd restored", reg_ovrd, 16'h0F41);
    ck("R3", "training bit blocks up then link_up", n_up - b_up, 1);
    ck("R4", "last_state stuck", last_state, 6'h0D);
    ck("R2", "cap_wdata gen1 again", cap_seen, 32'h0000_00F1);

    // R5 R12: receiver valid, no override; second start ignored
    rx_bit = 1'b1; dbg_hi = 32'h0;
    run(32'h1, 3, 0, 1);
    ck("R5", "no ovrd access", (n_rd_ov - b_rdov) + (n_wr_ov - b_wrov), 0);
    ck("R4", "rx reads before up", n_rd_rx - b_rx, 3);
    ck("R12", "single cap write", n_cap - b_cap, 1);
    ck("R12", "single done", n_done - b_done, 1);
    ck("R12", "link_up", n_up - b_up, 1);

    // R9 timeout, stuck every poll, override bits preset
    rx_bit = 1'b0; dbg_hi = 32'h2000_0010; reg_ovrd = 16'h80AC;
    run(32'h0, 0, 0, 0);
    ck("R9", "fail", n_fail - b_fail, 1);
    ck("R9", "rx reads", n_rd_rx - b_rx, MAXC);
    ck("R6", "ovrd writes each poll", n_wr_ov - b_wrov, 2*MAXC);
    ck("R6", "ovrd bits cleared", reg_ovrd, 16'h8084);

    // R10 PHY error during recovery
    inj_err = 1'b1; err_seen = 0;
    run(32'h0, 0, 0, 0);
    inj_err = 1'b0;
    repeat (5) @(negedge clk);
    ck("R10", "fail", n_fail - b_fail, 1);
    ck("R10", "done", n_done - b_done, 1);
    ck("R10", "no request after error", n_req_after_err, 0);
    ck("R10", "no ovrd read completed", n_rd_ov - b_rdov, 0);

    // random runs
    for (int i = 0; i < 8; i++) begin
      logic [31:0] lo, hi; logic rx; logic [15:0] ov; bit up, st;
      lo = $urandom; hi = $urandom;
      if ($urandom % 2) lo[5:0] = 6'h0D;
      hi[4] = ($urandom % 3) == 0; hi[29] = ($urandom % 2);
      rx = $urandom; ov = $urandom;
      dbg_lo = lo; dbg_hi = hi; rx_bit = rx; reg_ovrd = ov;
      up = exp_up(hi); st = exp_stuck(lo, rx);
      run($urandom, 0, 0, 0);
      ck("R3", "random up", n_up - b_up, up);
      ck("R9", "random fail", n_fail - b_fail, !up);
      ck("R4", "random rx reads", n_rd_rx - b_rx, up ? 0 : MAXC);
      ck("R5", "random ovrd writes", n_wr_ov - b_wrov, (!up && st) ? 2*MAXC : 0);
      ck("R6", "random ovrd value", reg_ovrd, (!up && st) ? (ov & ~16'h0028) : ov);
      ck("R4", "random last_state", last_state, lo[5:0]);
    end

    ck("R7", "hold windows seen", n_hold > 0, 1);
    ck("R7", "hold window violations", v_hold, 0);
    ck("R8", "gap windows seen", n_gap > 0, 1);
    ck("R8", "gap window violations", v_gap, 0);
    ck("R11", "unexpected addresses", n_other, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule